// File: doc/BRIEF.md
# I2C-Configured Four-Way Input Multiplexer

This block is an I2C target that owns a five-bit configuration value and uses it to steer four outputs. A single select pin chooses, for all four outputs at once, whether each one follows its own bit of a four-bit parallel input or the matching low bit of the stored value. The top bit of the stored value drives a separate auxiliary output that never passes through the multiplexer.

A bus master changes the stored value with a one-byte write to the block's seven-bit address, which is a parameter, and reads it back with a one-byte read. A write-protect pin makes the block accept and acknowledge a data byte but throw it away. A force-low pin pulls every output that comes from the stored value to zero and leaves the parallel path alone. A written value takes effect only at the STOP condition that ends the transfer, so the outputs, and the auxiliary output in particular, stay steady while the transfer is in progress.

The bus lines are sampled by a fast system clock, passed through synchronisers and turned into edge events. The block only ever pulls SDA low, through an output enable. The design has no notion of bit rate, so it works at 100 kbit/s and at 400 kbit/s as long as the system clock is many times faster than SCL.

Top module: `i2c_mux_cfg`

## Requirements
- R1: After reset the stored value is 0, so the auxiliary output is 0, every output taken from the stored value is 0, and the SDA output enable is 0.
- R2: When `sel` is 0, `mux_out[n]` equals `par_in[n]` for every n from 0 to 3, whatever the stored value and `force_low` are.
- R3: When `sel` is 1 and `force_low` is 0, `mux_out[n]` equals bit n of the stored value for every n from 0 to 3.
- R4: `aux_out` equals bit 4 of the stored value whatever `sel` is, provided `force_low` is 0.
- R5: While `force_low` is 1, `aux_out` is 0 and, when `sel` is 1, `mux_out` is 0. The stored value itself is kept.
- R6: A write is a START, the address byte {ADDR, 0}, and one data byte. The block acknowledges the address byte and the data byte by pulling SDA low in the ninth clock of each, and stores data bits 4..0.
- R7: A written value changes neither the stored value nor any output until the STOP condition is detected. It takes effect within a few system clocks of that STOP.
- R8: If `wp` is 1 when the eighth data bit has been clocked in, the data byte is still acknowledged but is discarded, and the stored value stays as it was.
- R9: A read is a START and the address byte {ADDR, 1}. The block acknowledges, then sends {3'b000, stored[4:0]} MSB first, and releases SDA after the eighth bit. A NACK from the master ends the transfer.
- R10: An address byte whose upper seven bits differ from ADDR is not acknowledged, and the data that follows it changes nothing.
- R11: The block only ever pulls SDA low, by setting `sda_oe`. `sda_oe` changes only after an SCL falling edge, a START or a STOP, and never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| sel | input | 1 | 0 picks the parallel input, 1 picks the stored bits |
| par_in | input | 4 | Parallel input bits |
| wp | input | 1 | Write protect, 1 discards written data |
| force_low | input | 1 | Forces the outputs taken from the stored value to 0 |
| mux_out | output | 4 | Multiplexed outputs |
| aux_out | output | 1 | Stored bit 4, not multiplexed |

## Verification
On every cycle the assertions check three things: the stored value moves only in the cycle after a detected STOP, `sda_oe` only moves after an SCL fall, START or STOP, and a pending write is armed only while write protect is low. They also check that the force-low pin holds every output taken from the stored value at zero. Only the bench's scenarios can show the rest. These are whole transfers against the right and the wrong address, the acknowledge bits the master sees, the order of the bits in a read-back byte, and the output values before and after a STOP under each combination of select, override and write protect.

// File: rtl/i2c_mux_cfg_pkg.sv
// Package: shared widths and the transfer state encoding for the
// I2C-configured multiplexer. Assumes an 8-bit byte on the bus.
package i2c_mux_cfg_pkg;
    localparam int MUX_W  = 4;
    localparam int CFG_W  = MUX_W + 1;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_CHK,
        ST_ACK_ADDR,
        ST_WR,
        ST_WR_CHK,
        ST_ACK_WR,
        ST_RD,
        ST_RD_ACK
    } xfer_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL and SDA into the clock domain through a chain of
// STAGES flops each and derives SCL edges, START and STOP.
// Assumes both lines idle high and STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the raw line level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    assign scl_lvl   = lvl[1];
    assign sda_lvl   = lvl[0];
    assign scl_rise  = lvl[1] & ~prev[1];
    assign scl_fall  = ~lvl[1] & prev[1];
    assign start_evt = lvl[1] & prev[1] & prev[0] & ~lvl[0];
    assign stop_evt  = lvl[1] & prev[1] & ~prev[0] & lvl[0];
endmodule

// File: rtl/i2c_cfg_target.sv
// Module: I2C target state machine that holds the configuration value.
// It handles one data byte per write and per read, and commits a write
// only at STOP. Assumes events come from i2c_line_sync.
module i2c_cfg_target
    import i2c_mux_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR = 7'h2C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             wp,
    output logic [CFG_W-1:0] cfg_q,
    output logic             sda_oe
);
    xfer_state_t        state;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  txsh;
    logic [BYTE_W-1:0]  rd_byte;
    logic [CFG_W-1:0]   pend;
    logic               pend_valid;
    logic               rnw;

    // Byte returned on a read: stored bits low, zeros above.
    assign rd_byte = {{(BYTE_W-CFG_W){1'b0}}, cfg_q};

    // Walk the transfer, drive the acknowledge and read bits, and commit at STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            txsh       <= '0;
            pend       <= '0;
            pend_valid <= 1'b0;
            rnw        <= 1'b0;
            sda_oe     <= 1'b0;
            cfg_q      <= '0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            if (pend_valid) begin
                cfg_q      <= pend;
                pend_valid <= 1'b0;
            end
        end else if (start_evt) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W-1))
                            state <= (state == ST_ADDR) ? ST_ADDR_CHK : ST_WR_CHK;
                    end
                end
                ST_ADDR_CHK: begin
                    if (scl_fall) begin
                        if (shreg[BYTE_W-1:1] == ADDR) begin
                            sda_oe <= 1'b1;
                            rnw    <= shreg[0];
                            state  <= ST_ACK_ADDR;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rnw) begin
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            txsh   <= {rd_byte[BYTE_W-2:0], 1'b0};
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                end
                ST_WR_CHK: begin
                    if (scl_fall) begin
                        sda_oe     <= 1'b1;
                        pend       <= shreg[CFG_W-1:0];
                        pend_valid <= ~wp;
                        state      <= ST_ACK_WR;
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W-1)) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_RD_ACK;
                        end else begin
                            sda_oe <= ~txsh[BYTE_W-1];
                            txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // The stored value moves only right after a STOP.
    assert_commit_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(stop_evt));

    // A pending write is armed only while write protect is low.
    assert_wp_discards_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid) |-> !$past(wp));

    // SDA drive moves only after an SCL fall, START or STOP.
    assert_sda_on_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

    // SDA drive never changes while SCL has been high for two samples.
    assert_sda_steady_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(stop_evt) && !$past(start_evt)) |-> $stable(sda_oe));
endmodule

// File: rtl/cfg_out_stage.sv
// Module: output stage. One mux per output picks the parallel bit or
// the gated stored bit. The top stored bit drives the auxiliary output.
// Assumes cfg holds MUX_W mux bits plus one auxiliary bit on top.
module cfg_out_stage #(
    parameter int MUX_W = 4,
    localparam int CFG_W = MUX_W + 1
) (
    input  logic [CFG_W-1:0] cfg,
    input  logic             sel,
    input  logic             force_low,
    input  logic [MUX_W-1:0] par_in,
    output logic [MUX_W-1:0] mux_out,
    output logic             aux_out
);
    logic [CFG_W-1:0] gated;

    // Clear every stored-value bit while the override is active.
    always_comb gated = cfg & {CFG_W{~force_low}};

    for (genvar n = 0; n < MUX_W; n++) begin : g_mux
        assign mux_out[n] = sel ? gated[n] : par_in[n];
    end

    assign aux_out = gated[CFG_W-1];
endmodule

// File: rtl/i2c_mux_cfg.sv
// Module: top of the I2C-configured multiplexer. It chains the line
// synchroniser, the target state machine and the output stage.
// Assumes clk runs many times faster than SCL.
module i2c_mux_cfg
    import i2c_mux_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR = 7'h2C,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             sel,
    input  logic [MUX_W-1:0] par_in,
    input  logic             wp,
    input  logic             force_low,
    output logic [MUX_W-1:0] mux_out,
    output logic             aux_out
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [CFG_W-1:0] cfg_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_cfg_target #(.ADDR(ADDR)) u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .wp        (wp),
        .cfg_q     (cfg_q),
        .sda_oe    (sda_oe)
    );

    cfg_out_stage #(.MUX_W(MUX_W)) u_out (
        .cfg       (cfg_q),
        .sel       (sel),
        .force_low (force_low),
        .par_in    (par_in),
        .mux_out   (mux_out),
        .aux_out   (aux_out)
    );

    // The override holds every output taken from the stored value at zero.
    assert_override_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |-> (!aux_out && (!sel || mux_out == '0)));
endmodule

// File: tb/sim_i2c_mux_cfg.sv
// Bench: a table of write/output vectors walked by one loop, then
// directed tests for reset, STOP timing, wrong address and read NACK.
module sim_i2c_mux_cfg;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam int Q = 10;
    localparam int NV = 8;
    // {wp, sel, force_low, par_in[3:0], wdata[7:0], exp_mux[3:0], exp_aux}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 4'hA, 8'hE5, 4'h5, 1'b0},
        {1'b0, 1'b1, 1'b0, 4'h3, 8'h1A, 4'hA, 1'b1},
        {1'b1, 1'b1, 1'b0, 4'h0, 8'h07, 4'hA, 1'b1},
        {1'b0, 1'b0, 1'b0, 4'h6, 8'h13, 4'h6, 1'b1},
        {1'b0, 1'b1, 1'b1, 4'h9, 8'h0F, 4'h0, 1'b0},
        {1'b0, 1'b0, 1'b1, 4'hC, 8'hF0, 4'hC, 1'b0},
        {1'b1, 1'b1, 1'b0, 4'hF, 8'h00, 4'h0, 1'b1},
        {1'b0, 1'b1, 1'b0, 4'h0, 8'hFF, 4'hF, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sel = 1'b0, wp = 1'b0, force_low = 1'b0;
    logic [3:0] par_in = '0;
    logic sda_oe, aux_out;
    logic [3:0] mux_out;
    logic sda_line;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    i2c_mux_cfg #(.ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .sel(sel), .par_in(par_in), .wp(wp),
        .force_low(force_low), .mux_out(mux_out), .aux_out(aux_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gap();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; gap();
        m_sda = 1'b0; gap();
        m_scl = 1'b0; gap();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; gap();
        m_scl = 1'b1; gap();
        m_sda = 1'b1; gap();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; gap();
            m_scl = 1'b1; gap(); gap();
            m_scl = 1'b0; gap();
        end
        m_sda = 1'b1; gap();
        m_scl = 1'b1; gap();
        acked = ~sda_line; gap();
        m_scl = 1'b0; gap();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; gap();
            m_scl = 1'b1; gap();
            b[i] = sda_line; gap();
            m_scl = 1'b0; gap();
        end
        m_sda = nack; gap();
        m_scl = 1'b1; gap(); gap();
        m_scl = 1'b0; gap();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input logic stop,
                            output logic ack_a, output logic ack_d);
        bus_start();
        send_byte({a, 1'b0}, ack_a);
        send_byte(d, ack_d);
        if (stop) bus_stop();
    endtask

    task automatic do_read(output logic ack_a, output logic [7:0] d);
        bus_start();
        send_byte({ADDR, 1'b1}, ack_a);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic aa, ad;
        logic [7:0] rd;
        logic [4:0] model;
        model = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        gap();

        // R1: reset state
        sel = 1'b1; @(negedge clk);
        check("R1 mux_out", mux_out, 0);
        check("R1 aux_out", aux_out, 0);
        check("R1 sda_oe", sda_oe, 0);

        // Vector table: write, set controls, check outputs, read back.
        for (int v = 0; v < NV; v++) begin
            wp = VEC[v][19];
            do_write(ADDR, VEC[v][12:5], 1'b1, aa, ad);
            check("R6 address ack", aa, 1);
            check(VEC[v][19] ? "R8 data ack under wp" : "R6 data ack", ad, 1);
            if (!VEC[v][19]) model = VEC[v][9:5];
            wp = 1'b0;
            sel = VEC[v][18]; force_low = VEC[v][17]; par_in = VEC[v][16:13];
            @(negedge clk);
            check("R2 R3 R5 R8 mux_out", mux_out, VEC[v][4:1]);
            check("R4 R5 aux_out", aux_out, VEC[v][0]);
            do_read(aa, rd);
            check("R9 read ack", aa, 1);
            check("R9 read byte", rd, {3'b000, model});
            check("R11 released after read", sda_oe, 0);
        end
        // Stored value is now 5'h1F.

        // R7: new value is held back until STOP.
        sel = 1'b1; force_low = 1'b0;
        do_write(ADDR, 8'h04, 1'b0, aa, ad);
        gap();
        check("R7 mux_out before stop", mux_out, 4'hF);
        check("R7 aux_out before stop", aux_out, 1);
        bus_stop();
        check("R7 mux_out after stop", mux_out, 4'h4);
        check("R7 aux_out after stop", aux_out, 0);

        // R10: wrong address is not acknowledged and changes nothing.
        do_write(ADDR ^ 7'h01, 8'h1B, 1'b1, aa, ad);
        check("R10 no address ack", aa, 0);
        check("R10 no data ack", ad, 0);
        check("R10 mux_out unchanged", mux_out, 4'h4);
        do_read(aa, rd);
        check("R10 stored unchanged", rd, 8'h04);

        // R5: override keeps the stored value; releasing it restores outputs.
        force_low = 1'b1; @(negedge clk);
        check("R5 mux_out forced", mux_out, 0);
        force_low = 1'b0; @(negedge clk);
        check("R5 mux_out restored", mux_out, 4'h4);

        // R1: reset clears the stored value.
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R1 mux_out after reset", mux_out, 0);
        check("R1 sda_oe after reset", sda_oe, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule